// File: doc/BRIEF.md
# Banked General Register File with Interruption Bank Switch

This block is a 32-entry general register file. Its upper half, registers 16 to 31, exists in two physical copies. A one-bit bank selector decides which copy all accesses reach. Registers 1 to 15 are common to both settings, and register 0 is hardwired to zero. The file has two combinational read ports and one write port, all indexed by a 5-bit register number.

The bank selector is driven by three control inputs:

- Taking an interruption clears the selector. The handler then works in the alternate bank and leaves the interrupted program's upper registers untouched.
- A bank-switch instruction sets the selector, which returns access to the original bank.
- A return from interruption loads the selector from a saved copy supplied by the interruption status logic.

Beside the general registers sit kernel registers, eight by default. Any code can read them, but only privileged code can write them. An unprivileged write is dropped, and a one-cycle fault pulse reports it.

Top module: `banked_regfile`

## Requirements
- R1: Register 0 always reads as zero on both read ports, and a write to register 0 has no effect.
- R2: Registers 1 to 15 are a single copy: a value written under one bank setting reads back unchanged under the other.
- R3: Registers 16 to 31 have two copies. `bank_sel`=1 selects the original bank and `bank_sel`=0 selects the alternate bank. A value written in one bank is not visible in the other.
- R4: `intr_take` clears `bank_sel` in the next cycle. It has priority over `intr_ret` and `bank_sw` asserted in the same cycle.
- R5: `bank_sw`, with neither `intr_take` nor `intr_ret` asserted, sets `bank_sel` in the next cycle.
- R6: `intr_ret`, without `intr_take`, loads `bank_sel` from `saved_bank` in the next cycle. It has priority over `bank_sw`.
- R7: A bank change takes effect from the next cycle. A read or a write in the same cycle as the change uses the old bank.
- R8: After reset, `bank_sel` is 1, every register reads zero and `priv_fault` is 0.
- R9: Kernel registers are readable through `kr_rd_idx`/`kr_rd_data` regardless of `priv`. A write with `priv`=1 is visible from the next cycle.
- R10: A kernel write with `priv`=0 leaves the contents unchanged. It raises `priv_fault` for exactly the following cycle. A write with `priv`=1 raises no fault.
- R11: A general write lands at the clock edge. A read of the same register in the write's cycle returns the old value.
- R12: With no bank control input asserted, `bank_sel` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 5 | General write register number |
| wr_data | input | DW | General write data |
| intr_take | input | 1 | Interruption taken this cycle |
| bank_sw | input | 1 | Bank-switch-to-one instruction |
| intr_ret | input | 1 | Return from interruption |
| saved_bank | input | 1 | Saved bank bit restored on return |
| bank_sel | output | 1 | Current bank selector |
| kr_rd_idx | input | KAW | Kernel register read index |
| kr_rd_data | output | DW | Kernel register read data |
| kr_wr_en | input | 1 | Kernel register write request |
| kr_wr_idx | input | KAW | Kernel register write index |
| kr_wr_data | input | DW | Kernel register write data |
| priv | input | 1 | Requester is privileged |
| priv_fault | output | 1 | One-cycle pulse for a rejected kernel write |

## Verification
The assertions check the following on every cycle:
- the selector's next value under each combination of interruption, return and switch;
- the selector holding when no control input is asserted;
- the zero reading of register 0;
- the exact one-cycle fault pulse;
- unchanged kernel contents after a rejected write.

Only the bench's scenarios can show the data behaviour of the banking:
- an upper register written in one bank stays invisible in the other and survives a round trip;
- lower registers are shared;
- a read or a write issued in the same cycle as a switch still reaches the old bank.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW  = 64,
  parameter int KRN = 8,
  parameter int KAW = (KRN > 1) ? $clog2(KRN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [4:0]     rd_a_idx,
  output logic [DW-1:0]  rd_a_data,
  input  logic [4:0]     rd_b_idx,
  output logic [DW-1:0]  rd_b_data,
  input  logic           wr_en,
  input  logic [4:0]     wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic           intr_take,
  input  logic           bank_sw,
  input  logic           intr_ret,
  input  logic           saved_bank,
  output logic           bank_sel,
  input  logic [KAW-1:0] kr_rd_idx,
  output logic [DW-1:0]  kr_rd_data,
  input  logic           kr_wr_en,
  input  logic [KAW-1:0] kr_wr_idx,
  input  logic [DW-1:0]  kr_wr_data,
  input  logic           priv,
  output logic           priv_fault
);
  logic [DW-1:0] lo_q  [0:15];
  logic [DW-1:0] hi0_q [0:15];
  logic [DW-1:0] hi1_q [0:15];
  logic [DW-1:0] kr_q  [0:KRN-1];
  logic          bank_q;
  logic          bank_d;
  logic          fault_q;

  function automatic logic [DW-1:0] rd_sel(input logic [4:0] idx,
                                           input logic [DW-1:0] lo,
                                           input logic [DW-1:0] h0,
                                           input logic [DW-1:0] h1,
                                           input logic bk);
    if (idx == 5'd0)  return '0;
    if (!idx[4])      return lo;
    return bk ? h1 : h0;
  endfunction

  assign rd_a_data = rd_sel(rd_a_idx, lo_q[rd_a_idx[3:0]], hi0_q[rd_a_idx[3:0]],
                            hi1_q[rd_a_idx[3:0]], bank_q);
  assign rd_b_data = rd_sel(rd_b_idx, lo_q[rd_b_idx[3:0]], hi0_q[rd_b_idx[3:0]],
                            hi1_q[rd_b_idx[3:0]], bank_q);
  assign kr_rd_data = kr_q[kr_rd_idx];
  assign bank_sel   = bank_q;
  assign priv_fault = fault_q;

  always_comb begin
    if (intr_take)     bank_d = 1'b0;
    else if (intr_ret) bank_d = saved_bank;
    else if (bank_sw)  bank_d = 1'b1;
    else               bank_d = bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      bank_q  <= bank_d;
      fault_q <= kr_wr_en & ~priv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        lo_q[i]  <= '0;
        hi0_q[i] <= '0;
        hi1_q[i] <= '0;
      end
    end else if (wr_en && wr_idx != 5'd0) begin
      if (!wr_idx[4])   lo_q[wr_idx[3:0]]  <= wr_data;
      else if (bank_q)  hi1_q[wr_idx[3:0]] <= wr_data;
      else              hi0_q[wr_idx[3:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < KRN; k++) kr_q[k] <= '0;
    end else if (kr_wr_en && priv) begin
      kr_q[kr_wr_idx] <= kr_wr_data;
    end
  end
endmodule

// File: rtl/banked_regfile_checks.sv
module banked_regfile_checks #(
  parameter int DW  = 64,
  parameter int KAW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [4:0]     rd_a_idx,
  input logic [DW-1:0]  rd_a_data,
  input logic [4:0]     rd_b_idx,
  input logic [DW-1:0]  rd_b_data,
  input logic           intr_take,
  input logic           bank_sw,
  input logic           intr_ret,
  input logic           saved_bank,
  input logic           bank_sel,
  input logic [KAW-1:0] kr_rd_idx,
  input logic [DW-1:0]  kr_rd_data,
  input logic           kr_wr_en,
  input logic           priv,
  input logic           priv_fault
);
  a_r1_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 5'd0 |-> rd_a_data == '0);
  a_r1_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_idx == 5'd0 |-> rd_b_data == '0);
  a_r4_intr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    intr_take |=> !bank_sel);
  a_r5_switch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sw && !intr_take && !intr_ret |=> bank_sel);
  a_r6_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ret && !intr_take |=> bank_sel == $past(saved_bank));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_take && !intr_ret && !bank_sw |=> $stable(bank_sel));
  a_r10_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    kr_wr_en && !priv |=> priv_fault);
  a_r10_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(kr_wr_en && !priv) |=> !priv_fault);
  a_r10_kr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    kr_wr_en && !priv |=> (kr_rd_idx != $past(kr_rd_idx)) || (kr_rd_data == $past(kr_rd_data)));
endmodule

bind banked_regfile banked_regfile_checks #(.DW(DW), .KAW(KAW)) u_checks (
  .clk(clk), .rst_n(rst_n),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .intr_take(intr_take), .bank_sw(bank_sw), .intr_ret(intr_ret),
  .saved_bank(saved_bank), .bank_sel(bank_sel),
  .kr_rd_idx(kr_rd_idx), .kr_rd_data(kr_rd_data),
  .kr_wr_en(kr_wr_en), .priv(priv), .priv_fault(priv_fault)
);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
  localparam int DW = 64;
  localparam int KAW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0, kr_rd_data, kr_wr_data = '0;
  logic wr_en = 0, intr_take = 0, bank_sw = 0, intr_ret = 0, saved_bank = 0;
  logic bank_sel, kr_wr_en = 0, priv = 0, priv_fault;
  logic [KAW-1:0] kr_rd_idx = '0, kr_wr_idx = '0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  banked_regfile #(.DW(DW), .KRN(8), .KAW(KAW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .intr_take(intr_take), .bank_sw(bank_sw), .intr_ret(intr_ret),
    .saved_bank(saved_bank), .bank_sel(bank_sel),
    .kr_rd_idx(kr_rd_idx), .kr_rd_data(kr_rd_data),
    .kr_wr_en(kr_wr_en), .kr_wr_idx(kr_wr_idx), .kr_wr_data(kr_wr_data),
    .priv(priv), .priv_fault(priv_fault)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  task automatic gwrite(input logic [4:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_a(input logic [4:0] idx, output logic [DW-1:0] d);
    rd_a_idx = idx;
    #0.5;
    d = rd_a_data;
  endtask

  task automatic pulse(input logic it, input logic sw, input logic rt, input logic sb);
    @(negedge clk);
    intr_take = it; bank_sw = sw; intr_ret = rt; saved_bank = sb;
    @(negedge clk);
    intr_take = 0; bank_sw = 0; intr_ret = 0; saved_bank = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    #0.5;
    chk("R8 bank after reset", {63'd0, bank_sel}, 1);
    chk("R8 fault after reset", {63'd0, priv_fault}, 0);
    read_a(5'd20, d); chk("R8 r20 zero", d, 0);
    read_a(5'd7, d);  chk("R8 r7 zero", d, 0);
    kr_rd_idx = 3'd5; #0.5; chk("R8 kr5 zero", kr_rd_data, 0);
  endtask

  task automatic t_zero();
    logic [DW-1:0] d;
    gwrite(5'd0, 64'hDEAD);
    read_a(5'd0, d); chk("R1 r0 port a", d, 0);
    rd_b_idx = 5'd0; #0.5; chk("R1 r0 port b", rd_b_data, 0);
  endtask

  task automatic t_banks();
    logic [DW-1:0] d;
    gwrite(5'd16, 64'hA1A1);
    gwrite(5'd5, 64'hC5C5);
    gwrite(5'd31, 64'h3131);
    pulse(1, 0, 0, 0);
    #0.5; chk("R4 bank cleared", {63'd0, bank_sel}, 0);
    read_a(5'd16, d); chk("R3 alt bank r16 empty", d, 0);
    read_a(5'd31, d); chk("R3 alt bank r31 empty", d, 0);
    read_a(5'd5, d);  chk("R2 r5 shared", d, 64'hC5C5);
    gwrite(5'd16, 64'hB2B2);
    gwrite(5'd9, 64'h9999);
    pulse(0, 1, 0, 0);
    #0.5; chk("R5 bank set", {63'd0, bank_sel}, 1);
    read_a(5'd16, d); chk("R3 orig bank r16", d, 64'hA1A1);
    rd_b_idx = 5'd9; #0.5; chk("R2 r9 shared", rd_b_data, 64'h9999);
    pulse(1, 0, 0, 0);
    read_a(5'd16, d); chk("R3 alt bank r16 kept", d, 64'hB2B2);
    pulse(0, 0, 1, 1);
    #0.5; chk("R6 restore 1", {63'd0, bank_sel}, 1);
    read_a(5'd16, d); chk("R6 orig bank back", d, 64'hA1A1);
    pulse(0, 0, 0, 0);
    #0.5; chk("R12 bank holds", {63'd0, bank_sel}, 1);
  endtask

  task automatic t_priority();
    pulse(1, 1, 0, 0); #0.5; chk("R4 intr over switch", {63'd0, bank_sel}, 0);
    pulse(0, 1, 0, 0);
    pulse(1, 0, 1, 1); #0.5; chk("R4 intr over return", {63'd0, bank_sel}, 0);
    pulse(0, 1, 1, 0); #0.5; chk("R6 return over switch", {63'd0, bank_sel}, 0);
    pulse(0, 0, 1, 0); #0.5; chk("R6 restore 0", {63'd0, bank_sel}, 0);
    pulse(0, 1, 0, 0);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] d;
    @(negedge clk);
    intr_take = 1; rd_a_idx = 5'd16;
    wr_en = 1; wr_idx = 5'd17; wr_data = 64'h1717;
    #0.5; chk("R7 read uses old bank", rd_a_data, 64'hA1A1);
    @(negedge clk);
    intr_take = 0; wr_en = 0;
    read_a(5'd17, d); chk("R7 alt bank r17 untouched", d, 0);
    pulse(0, 1, 0, 0);
    read_a(5'd17, d); chk("R7 write went to old bank", d, 64'h1717);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd12; wr_data = 64'h1212; rd_a_idx = 5'd12;
    #0.5; chk("R11 same-cycle read old", rd_a_data, 0);
    @(negedge clk);
    wr_en = 0;
    #0.5; chk("R11 read after write", rd_a_data, 64'h1212);
  endtask

  task automatic t_kernel();
    @(negedge clk);
    kr_wr_en = 1; kr_wr_idx = 3'd3; kr_wr_data = 64'h3333; priv = 1;
    @(negedge clk);
    kr_wr_en = 0; priv = 0; kr_rd_idx = 3'd3;
    #0.5;
    chk("R9 priv write visible", kr_rd_data, 64'h3333);
    chk("R10 no fault on priv write", {63'd0, priv_fault}, 0);
    @(negedge clk);
    kr_wr_en = 1; kr_wr_idx = 3'd3; kr_wr_data = 64'hBAD0; priv = 0;
    #0.5; chk("R10 no fault in write cycle", {63'd0, priv_fault}, 0);
    @(negedge clk);
    kr_wr_en = 0;
    #0.5;
    chk("R10 fault pulse", {63'd0, priv_fault}, 1);
    chk("R10 kr3 unchanged", kr_rd_data, 64'h3333);
    step();
    chk("R10 fault one cycle", {63'd0, priv_fault}, 0);
    kr_rd_idx = 3'd7; #0.5; chk("R9 kr7 read unprivileged", kr_rd_data, 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    t_reset();
    t_zero();
    t_banks();
    t_priority();
    t_same_cycle();
    t_kernel();
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule